// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Sequencer

This block decides, cycle by cycle, what each clock output of a clock generator is doing. It governs six differential output pairs and one single-ended reference output. Each output is in one of three states: running, driven low (both legs low on a pair), or high impedance. Its inputs are the power-good / power-down pin, a lock flag from the PLL, one active-low enable pin per pair, a three-level spread strap already decoded to two bits, an address-select strap, and control fields from the serial management registers. The state codes drive the output buffers and the clock gating cells next to them. The block also gives the spread setting the modulator should use.

The first high level of the power-good pin marks the start of operation. At that moment the straps are captured and held. Later low periods are power-down, and later highs only leave power-down. All asynchronous pins pass through a two-flop synchronizer in the output clock domain. Every state code is registered and changes only at a rising edge, so a downstream gate always passes or blocks whole clock periods.

Top module: `clk_out_sequencer`

## Requirements
- R1: While reset is high and on the cycle after it, every pair state is LOW (code 00), the reference state is HIZ (code 10), and the spread code, strap readback and latched address select are all 0.
- R2: The spread strap (input 00 = low, 01 = mid, 10 or 11 = high) and the address strap are captured at the first power-good high after reset. The readback codes are 00, 01 and 11. Later power-down and power-good cycles do not capture them again.
- R3: When the software-select bit is 1, the spread code follows the two software bits one edge later, and the reserved software value 10 gives 00. When the bit is 0, the spread code equals the strap readback.
- R4: While power-good is low, and before the first power-good high, every pair is LOW (00), whatever its pin or register enable.
- R5: With power-good high and the PLL locked, a pair is RUN (01) exactly when its register enable is 1 and its enable pin is 0. Otherwise it is LOW (00). A register enable of 0 overrides the pin.
- R6: While the synchronized lock flag is low, every pair is LOW. The pairs come back as soon as lock returns.
- R7: A change on a pair's enable pin reaches that pair's state code on the third rising edge after the pin changes, and not before.
- R8: The reference is HIZ (10) until the first power-good high. After that it is LOW (00) whenever its register enable is 0. Otherwise it is RUN (01) with power-good high. In power-down it is RUN if the wake bit is 1 and LOW if the wake bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock domain clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Power good (high) / power-down (low), asynchronous |
| pll_lock | input | 1 | PLL lock flag, asynchronous |
| oe_n | input | NUM_DIF | Active-low enable pin per pair, asynchronous |
| strap_lvl | input | 2 | Decoded spread strap: 00 low, 01 mid, 1x high |
| addr_strap | input | 1 | Address-select strap |
| reg_dif_en | input | NUM_DIF | Register enable per pair |
| reg_ss_sw_en | input | 1 | Software control of spread |
| reg_ss_sw | input | 2 | Software spread code |
| reg_ref_en | input | 1 | Register enable for the reference output |
| reg_ref_wol | input | 1 | Keep reference running in power-down |
| dif_state | output | 2*NUM_DIF | Pair i state at bits [2i+1:2i] |
| ref_state | output | 2 | Reference output state |
| spread_code | output | 2 | Effective spread code |
| strap_rb | output | 2 | Latched strap readback code |
| addr_sel | output | 1 | Latched address select |

## Verification
A table of combinations drives the main gating function. It sweeps power-good, lock, the wake bit, the reference enable and patterns of pins against register enables. Single-lane, alternating and complementary patterns separate the pin path from the register override, and both of those from the global blocking by power-down and lock. Directed runs try each strap level over a reset. They then toggle power-good with changed straps to show that no second capture happens. They step the spread software bits through the reserved value, and they time one pin change edge by edge to pin the latency to the third edge.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  localparam logic [1:0] ST_LOW = 2'b00;
  localparam logic [1:0] ST_RUN = 2'b01;
  localparam logic [1:0] ST_HIZ = 2'b10;

  // three-level strap to readback code
  function automatic logic [1:0] strap_code(input logic [1:0] lvl);
    case (lvl)
      2'b00:   strap_code = 2'b00;
      2'b01:   strap_code = 2'b01;
      default: strap_code = 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/clkseq_sync.sv
module clkseq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/clkseq_power.sv
module clkseq_power (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_s,
  input  logic [1:0] strap_lvl,
  input  logic       addr_strap,
  output logic       live,
  output logic [1:0] strap_rb_q,
  output logic       addr_q
);
  import clkseq_pkg::*;

  logic started_q;

  assign live = started_q | pwr_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q  <= 1'b0;
      strap_rb_q <= 2'b00;
      addr_q     <= 1'b0;
    end else if (pwr_s && !started_q) begin
      started_q  <= 1'b1;
      strap_rb_q <= strap_code(strap_lvl);
      addr_q     <= addr_strap;
    end
  end

  // R2: once started, straps never change again
  a_r2_strap_frozen: assert property (@(posedge clk) disable iff (rst)
    started_q |=> ($stable(strap_rb_q) && $stable(addr_q)));
endmodule

// File: rtl/clkseq_lane.sv
module clkseq_lane (
  input  logic       clk,
  input  logic       rst,
  input  logic       allow,
  input  logic       reg_en,
  input  logic       pin_n_s,
  output logic [1:0] state_q
);
  import clkseq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_LOW;
    else if (allow && reg_en && !pin_n_s) state_q <= ST_RUN;
    else state_q <= ST_LOW;
  end

  // R4 / R6: power-down or missing lock blocks the lane
  a_r4_blocked_low: assert property (@(posedge clk) disable iff (rst)
    !allow |=> (state_q == ST_LOW));
  // R5: register override forces low
  a_r5_reg_override: assert property (@(posedge clk) disable iff (rst)
    !reg_en |=> (state_q == ST_LOW));
endmodule

// File: rtl/clk_out_sequencer.sv
module clk_out_sequencer #(
  parameter int NUM_DIF     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pwr_ok,
  input  logic                 pll_lock,
  input  logic [NUM_DIF-1:0]   oe_n,
  input  logic [1:0]           strap_lvl,
  input  logic                 addr_strap,
  input  logic [NUM_DIF-1:0]   reg_dif_en,
  input  logic                 reg_ss_sw_en,
  input  logic [1:0]           reg_ss_sw,
  input  logic                 reg_ref_en,
  input  logic                 reg_ref_wol,
  output logic [2*NUM_DIF-1:0] dif_state,
  output logic [1:0]           ref_state,
  output logic [1:0]           spread_code,
  output logic [1:0]           strap_rb,
  output logic                 addr_sel
);
  import clkseq_pkg::*;

  localparam int SYNC_W = NUM_DIF + 2;

  logic [SYNC_W-1:0]  sync_q;
  logic [NUM_DIF-1:0] oe_n_s;
  logic               pwr_s, lock_s, live, dif_allow;
  logic [1:0]         ss_next;

  clkseq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({pll_lock, pwr_ok, oe_n}), .q(sync_q)
  );
  assign oe_n_s = sync_q[NUM_DIF-1:0];
  assign pwr_s  = sync_q[NUM_DIF];
  assign lock_s = sync_q[NUM_DIF+1];

  clkseq_power u_power (
    .clk(clk), .rst(rst), .pwr_s(pwr_s), .strap_lvl(strap_lvl),
    .addr_strap(addr_strap), .live(live), .strap_rb_q(strap_rb), .addr_q(addr_sel)
  );

  assign dif_allow = pwr_s & lock_s;

  for (genvar g = 0; g < NUM_DIF; g++) begin : g_lane
    clkseq_lane u_lane (
      .clk(clk), .rst(rst), .allow(dif_allow), .reg_en(reg_dif_en[g]),
      .pin_n_s(oe_n_s[g]), .state_q(dif_state[2*g+1:2*g])
    );
  end

  always_comb begin
    if (!reg_ss_sw_en)           ss_next = strap_rb;
    else if (reg_ss_sw == 2'b10) ss_next = 2'b00;
    else                         ss_next = reg_ss_sw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_state   <= ST_HIZ;
      spread_code <= 2'b00;
    end else begin
      spread_code <= ss_next;
      if (!live)                      ref_state <= ST_HIZ;
      else if (!reg_ref_en)           ref_state <= ST_LOW;
      else if (pwr_s || reg_ref_wol)  ref_state <= ST_RUN;
      else                            ref_state <= ST_LOW;
    end
  end

  // R8: reference floats before the first power-good
  a_r8_ref_hiz_until_start: assert property (@(posedge clk) disable iff (rst)
    !live |=> (ref_state == ST_HIZ));
  // R8: disabled reference is driven low once started
  a_r8_ref_low_when_off: assert property (@(posedge clk) disable iff (rst)
    (live && !reg_ref_en) |=> (ref_state == ST_LOW));
  // R3: reserved spread code never reaches the modulator
  a_r3_no_reserved_code: assert property (@(posedge clk) disable iff (rst)
    spread_code != 2'b10);
endmodule

// File: tb/test_clk_out_sequencer.sv
module test_clk_out_sequencer;
  localparam int N = 6;

  logic clk = 0, rst = 1;
  logic pwr_ok = 0, pll_lock = 0, addr_strap = 0;
  logic [N-1:0] oe_n = '1, reg_dif_en = '1;
  logic [1:0] strap_lvl = 2'b00, reg_ss_sw = 2'b00;
  logic reg_ss_sw_en = 0, reg_ref_en = 1, reg_ref_wol = 0;
  logic [2*N-1:0] dif_state;
  logic [1:0] ref_state, spread_code, strap_rb;
  logic addr_sel;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clk_out_sequencer i_clk_out_sequencer (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .pll_lock(pll_lock), .oe_n(oe_n),
    .strap_lvl(strap_lvl), .addr_strap(addr_strap), .reg_dif_en(reg_dif_en),
    .reg_ss_sw_en(reg_ss_sw_en), .reg_ss_sw(reg_ss_sw), .reg_ref_en(reg_ref_en),
    .reg_ref_wol(reg_ref_wol), .dif_state(dif_state), .ref_state(ref_state),
    .spread_code(spread_code), .strap_rb(strap_rb), .addr_sel(addr_sel)
  );

  typedef struct packed {
    logic pwr, lock, wol, ren;
    logic [5:0] oe, den;
    logic [11:0] dif;
    logic [1:0] rf;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b1, 1'b1, 1'b0, 1'b1, 6'b000000, 6'b111111, 12'h555, 2'b01},
    '{1'b1, 1'b1, 1'b0, 1'b1, 6'b000011, 6'b111111, 12'h550, 2'b01},
    '{1'b1, 1'b1, 1'b0, 1'b1, 6'b000000, 6'b101010, 12'h444, 2'b01},
    '{1'b1, 1'b1, 1'b0, 1'b0, 6'b111100, 6'b111111, 12'h005, 2'b00},
    '{1'b0, 1'b1, 1'b0, 1'b1, 6'b000000, 6'b111111, 12'h000, 2'b00},
    '{1'b0, 1'b1, 1'b1, 1'b1, 6'b000000, 6'b111111, 12'h000, 2'b01},
    '{1'b0, 1'b1, 1'b1, 1'b0, 6'b000000, 6'b111111, 12'h000, 2'b00},
    '{1'b1, 1'b0, 1'b0, 1'b1, 6'b000000, 6'b111111, 12'h000, 2'b01},
    '{1'b1, 1'b1, 1'b0, 1'b1, 6'b100000, 6'b011111, 12'h155, 2'b01},
    '{1'b1, 1'b1, 1'b0, 1'b1, 6'b010101, 6'b111111, 12'h444, 2'b01}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic power_up(input logic [1:0] lvl, input logic adr);
    rst = 1; pwr_ok = 0; pll_lock = 1; oe_n = '0; reg_dif_en = '1;
    reg_ss_sw_en = 0; reg_ref_en = 1; reg_ref_wol = 0;
    strap_lvl = lvl; addr_strap = adr;
    tick(3);
    rst = 0;
    tick(4);
    chk("R4 pairs low before start", dif_state, 12'h000);
    chk("R8 ref hiz before start", ref_state, 2'b10);
    pwr_ok = 1;
    tick(2);
    chk("R8 ref hiz two edges after start", ref_state, 2'b10);
    tick(1);
    chk("R8 ref runs after start", ref_state, 2'b01);
    chk("R5 all pairs run", dif_state, 12'h555);
    chk("R2 address latched", addr_sel, adr);
    tick(1);
  endtask

  initial begin
    // R1 reset state
    tick(2);
    chk("R1 pairs low", dif_state, 12'h000);
    chk("R1 ref hiz", ref_state, 2'b10);
    chk("R1 spread", spread_code, 2'b00);
    chk("R1 readback", {strap_rb, addr_sel}, 3'b000);

    // R2 strap levels: low, high (11 input), mid last
    power_up(2'b00, 1'b0);
    chk("R2 strap low readback", strap_rb, 2'b00);
    power_up(2'b11, 1'b0);
    chk("R2 strap high readback", strap_rb, 2'b11);
    chk("R3 spread follows strap high", spread_code, 2'b11);
    power_up(2'b01, 1'b1);
    chk("R2 strap mid readback", strap_rb, 2'b01);
    chk("R3 spread follows strap mid", spread_code, 2'b01);

    // table walk: R4 R5 R6 R8
    for (int i = 0; i < 10; i++) begin
      pwr_ok = VEC[i].pwr; pll_lock = VEC[i].lock; reg_ref_wol = VEC[i].wol;
      reg_ref_en = VEC[i].ren; oe_n = VEC[i].oe; reg_dif_en = VEC[i].den;
      tick(4);
      chk($sformatf("R5 R4 R6 table pairs row %0d", i), dif_state, VEC[i].dif);
      chk($sformatf("R8 table ref row %0d", i), ref_state, VEC[i].rf);
    end

    // R7 pin latency
    pwr_ok = 1; pll_lock = 1; oe_n = '0; reg_dif_en = '1; reg_ref_en = 1;
    tick(4);
    oe_n[2] = 1'b1;
    tick(2);
    chk("R7 lane2 unchanged after two edges", dif_state[5:4], 2'b01);
    tick(1);
    chk("R7 lane2 stopped on third edge", dif_state[5:4], 2'b00);
    chk("R7 other lanes untouched", dif_state & 12'hFCF, 12'h545);
    oe_n[2] = 1'b0;
    tick(2);
    chk("R7 lane2 still stopped after two edges", dif_state[5:4], 2'b00);
    tick(1);
    chk("R7 lane2 restarted on third edge", dif_state[5:4], 2'b01);

    // R6 lock loss and return
    pll_lock = 0;
    tick(3);
    chk("R6 lock loss blocks pairs", dif_state, 12'h000);
    pll_lock = 1;
    tick(3);
    chk("R6 pairs resume on lock", dif_state, 12'h555);

    // R2 no second capture
    strap_lvl = 2'b10; addr_strap = 0;
    pwr_ok = 0; tick(5);
    pwr_ok = 1; tick(5);
    chk("R2 strap not resampled", strap_rb, 2'b01);
    chk("R2 address not resampled", addr_sel, 1'b1);

    // R3 software spread control
    reg_ss_sw_en = 1; reg_ss_sw = 2'b11;
    tick(1);
    chk("R3 software code 11", spread_code, 2'b11);
    reg_ss_sw = 2'b10;
    tick(1);
    chk("R3 reserved software code gives 00", spread_code, 2'b00);
    reg_ss_sw = 2'b00;
    tick(1);
    chk("R3 software code 00", spread_code, 2'b00);
    reg_ss_sw_en = 0;
    tick(1);
    chk("R3 strap selected again", spread_code, 2'b01);

    // R1 reset again mid-run
    rst = 1;
    tick(1);
    chk("R1 reset clears pairs", dif_state, 12'h000);
    chk("R1 reset floats ref", ref_state, 2'b10);
    chk("R1 reset clears straps", {strap_rb, addr_sel}, 3'b000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule